// File: doc/BRIEF.md
# Pulse-Count Decimator

This block turns the single-bit output of a delta-sigma modulator into multi-bit samples. Every clock cycle is one pulse slot. An interval timer divides the slot stream into back-to-back windows of `WIN_LEN` slots. The block counts the high slots in each window, and when the window closes it puts the count on a registered sample output with a one-cycle valid strobe.

The interval timer and the pulse slot run from the same clock. The full-scale value therefore depends only on the window length, and it is exactly `WIN_LEN`. The sample is latched and the counter restarts on the same clock edge. A pulse on that closing edge opens the next window's count, so no slot is lost or counted twice.

The first window after reset also spans exactly `WIN_LEN` slots. Because the input stream is quantised to clock slots, each sample differs from the ideal average by less than one count.

Top module: `pulse_count_decimator`

## Requirements
- R1: Windows follow one another with no gap. Each spans `WIN_LEN` consecutive slots, and the sample produced for a window equals the number of slots in it where `pulseIn` was high.
- R2: A window in which every slot is high yields exactly `WIN_LEN` (full scale). A window with no high slot yields 0.
- R3: The closing edge of a window is also the first slot of the next window. A pulse sampled on that edge is counted in the new window, so the counter restarts at 1 rather than 0.
- R4: The internal count and `sampleOut` never exceed `WIN_LEN`. `sampleOut` is `$clog2(WIN_LEN+1)` bits wide.
- R5: `sampleValid` is high for exactly one cycle per window. Consecutive valid strobes are exactly `WIN_LEN` cycles apart.
- R6: After reset is released, the first window covers the first `WIN_LEN` rising edges. Its `sampleValid` appears after rising edge number `WIN_LEN+1`.
- R7: `sampleOut` holds its value in every cycle between valid strobes.
- R8: Synchronous reset sets `sampleOut` to 0, drops `sampleValid`, and clears the counter and the interval timer. A partly filled window that is interrupted by reset produces no sample, and its pulses do not reach the next sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one pulse slot per cycle |
| rst | input | 1 | Synchronous reset, active high |
| pulseIn | input | 1 | Modulator bit stream, sampled each rising edge |
| sampleOut | output | $clog2(WIN_LEN+1) | Pulse count of the last completed window |
| sampleValid | output | 1 | High for one cycle when a new sample is presented |

## Verification
The main function is driven with all-low and all-high windows, which expose the two ends of the range and an off-by-one in the counter width or window length. An alternating pattern and a pseudo-random pattern produce mid-range counts that separate a correct tally from a stuck or shifted one. A window with a single pulse in its last slot, followed by one with a single pulse in its first slot, shows which window a boundary pulse lands in. A reset in the middle of a window of ones, followed by a window of zeros, shows whether stale pulses leak into the next sample.

// File: rtl/pcd_pkg.sv
`timescale 1ns/1ps
package pcd_pkg;

  // Strobes from the window control to the counting datapath
  typedef struct packed {
    logic latchSample;   // copy running count into the output register
    logic restartCount;  // begin a new window count with this slot
  } winStrobe_t;

endpackage

// File: rtl/pcd_window_ctrl.sv
`timescale 1ns/1ps
module pcd_window_ctrl #(
  parameter int WIN_LEN = 16,
  localparam int TMR_W = $clog2(WIN_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst,
  output pcd_pkg::winStrobe_t strobe
);

  localparam logic [TMR_W-1:0] LAST_SLOT = TMR_W'(WIN_LEN);
  localparam logic [TMR_W-1:0] AFTER_WRAP = TMR_W'(1);

  // Reset parks the timer at 0 so that the first window gets a full
  // WIN_LEN slots; later windows run 1..WIN_LEN, where the closing slot
  // is shared with the next window's first slot.
  logic [TMR_W-1:0] slotTimer;
  logic             closeNow;

  assign closeNow = (slotTimer == LAST_SLOT);

  always_ff @(posedge clk) begin
    if (rst)
      slotTimer <= '0;
    else if (closeNow)
      slotTimer <= AFTER_WRAP;
    else
      slotTimer <= slotTimer + AFTER_WRAP;
  end

  always_comb begin
    strobe.latchSample  = closeNow;
    strobe.restartCount = closeNow;
  end

  // R5
  timer_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    slotTimer <= LAST_SLOT);

  // R5
  timer_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.latchSample |=> (slotTimer == AFTER_WRAP));

  // R8
  timer_reset_chk: assert property (@(posedge clk)
    rst |=> (slotTimer == '0));

endmodule

// File: rtl/pcd_count_path.sv
`timescale 1ns/1ps
module pcd_count_path #(
  parameter int WIN_LEN = 16,
  localparam int CNT_W = $clog2(WIN_LEN + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pulseIn,
  input  pcd_pkg::winStrobe_t strobe,
  output logic [CNT_W-1:0]    sampleOut,
  output logic                sampleValid
);

  localparam logic [CNT_W-1:0] FULL_SCALE = CNT_W'(WIN_LEN);

  logic [CNT_W-1:0] runCount;
  logic [CNT_W-1:0] pulseExt;

  assign pulseExt = CNT_W'(pulseIn);

  always_ff @(posedge clk) begin
    if (rst)
      runCount <= '0;
    else if (strobe.restartCount)
      runCount <= pulseExt;
    else
      runCount <= runCount + pulseExt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sampleOut   <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= strobe.latchSample;
      if (strobe.latchSample)
        sampleOut <= runCount;
    end
  end

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    runCount <= FULL_SCALE);

  // R4
  sample_bound_chk: assert property (@(posedge clk) disable iff (rst)
    sampleOut <= FULL_SCALE);

  // R1
  sample_capture_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.latchSample |=> (sampleValid && sampleOut == $past(runCount)));

  // R3
  restart_seed_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.restartCount |=> (runCount == CNT_W'($past(pulseIn))));

  // R5
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    sampleValid |=> !sampleValid);

  // R7
  sample_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.latchSample |=> $stable(sampleOut));

  // R8
  path_reset_chk: assert property (@(posedge clk)
    rst |=> (sampleOut == '0 && !sampleValid && runCount == '0));

endmodule

// File: rtl/pulse_count_decimator.sv
`timescale 1ns/1ps
module pulse_count_decimator #(
  parameter int WIN_LEN = 16,
  localparam int CNT_W = $clog2(WIN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pulseIn,
  output logic [CNT_W-1:0] sampleOut,
  output logic             sampleValid
);

  pcd_pkg::winStrobe_t winStrobe;

  pcd_window_ctrl #(.WIN_LEN(WIN_LEN)) i_ctrl (
    .clk    (clk),
    .rst    (rst),
    .strobe (winStrobe)
  );

  pcd_count_path #(.WIN_LEN(WIN_LEN)) i_path (
    .clk         (clk),
    .rst         (rst),
    .pulseIn     (pulseIn),
    .strobe      (winStrobe),
    .sampleOut   (sampleOut),
    .sampleValid (sampleValid)
  );

endmodule

// File: tb/test_pulse_count_decimator.sv
`timescale 1ns/1ps
module test_pulse_count_decimator;

  localparam int N = 16;
  localparam int CW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pulseIn = 1'b0;
  logic [CW-1:0] sampleOut;
  logic          sampleValid;

  int checksDone = 0;
  int checksFailed = 0;
  int expQ[$];
  string tagQ[$];
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pulse_count_decimator #(.WIN_LEN(N)) i_pulse_count_decimator (
    .clk         (clk),
    .rst         (rst),
    .pulseIn     (pulseIn),
    .sampleOut   (sampleOut),
    .sampleValid (sampleValid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checksDone++;
    if (!ok) begin
      checksFailed++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a falling edge; leaves rst low at a falling edge
  task automatic applyReset();
    @(negedge clk);
    rst = 1'b1;
    pulseIn = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // Driver: one full window, slot 0 first; pushes the expected count
  task automatic driveWindow(input logic [N-1:0] pat, input string tag);
    int ones = 0;
    for (int i = 0; i < N; i++) begin
      pulseIn = pat[i];
      if (pat[i]) ones++;
      @(negedge clk);
    end
    expQ.push_back(ones);
    tagQ.push_back(tag);
  endtask

  // Monitor / scoreboard
  initial begin
    int gap = 0;
    bit seenFirst = 1'b0;
    int lastSample = 0;
    forever begin
      @(posedge clk);
      #1;
      if (rst) begin
        // R8 reset state
        check(sampleOut == '0 && !sampleValid, "R8",
              {27'd0, sampleValid, sampleOut}, 0);
        gap = 0;
        seenFirst = 1'b0;
        lastSample = 0;
      end else begin
        gap++;
        if (sampleValid) begin
          if (seenFirst)
            check(gap == N, "R5", gap, N);
          else
            check(gap == N + 1, "R6", gap, N + 1);
          if (expQ.size() == 0) begin
            check(1'b0, "R1", int'(sampleOut), -1);
          end else begin
            int e;
            string t;
            e = expQ.pop_front();
            t = tagQ.pop_front();
            check(int'(sampleOut) == e, t, int'(sampleOut), e);
          end
          gap = 0;
          seenFirst = 1'b1;
          lastSample = int'(sampleOut);
        end else begin
          // R7 hold between strobes
          check(int'(sampleOut) == lastSample, "R7", int'(sampleOut), lastSample);
        end
      end
    end
  end

  // Stimulus
  initial begin
    logic [N-1:0] lfsr;
    logic [N-1:0] alt;
    applyReset();
    driveWindow('0, "R2_zero");
    driveWindow('1, "R2_full");
    for (int i = 0; i < N; i++) alt[i] = i[0];
    driveWindow(alt, "R1_alt");
    driveWindow('0, "R2_zero");
    driveWindow(N'(1) << (N - 1), "R1_last");
    driveWindow(N'(1), "R3_first");
    driveWindow('0, "R3_after");
    driveWindow('1, "R3_full");
    lfsr = N'(16'hACE1);
    for (int w = 0; w < 3; w++) begin
      for (int s = 0; s < 7; s++)
        lfsr = {lfsr[N-2:0], lfsr[N-1] ^ lfsr[N/2] ^ lfsr[1] ^ lfsr[0]};
      driveWindow(lfsr, "R1_rand");
    end
    // R8: interrupt a window of ones, then expect a clean zero window
    pulseIn = 1'b0;
    @(negedge clk);  // closing slot of the last random window
    for (int i = 0; i < 5; i++) begin
      pulseIn = 1'b1;
      @(negedge clk);
    end
    applyReset();
    driveWindow('0, "R8_clean");
    driveWindow('1, "R2_full");
    pulseIn = 1'b0;
    repeat (4) @(negedge clk);
    // R1: every pushed window produced a sample
    check(expQ.size() == 0, "R1", expQ.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checksDone, checksFailed);
    $finish;
  end

  // Watchdog
  initial begin
    #(20 * 100000);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checksDone, checksFailed);
      $finish;
    end
  end

endmodule